// File: doc/BRIEF.md
# Ones'-Complement Sequential Multiply/Divide Unit

This unit performs multi-cycle multiply and divide on words in ones'-complement form for an 18-bit processor datapath. A multiply takes one operand from the in-out register and one from a memory operand. It returns the double-length product, with the high word on the accumulator output and the low word on the in-out output. A divide takes a double-length dividend, with the accumulator as the upper word and the in-out register as the lower word, and divides it by the memory operand. The quotient returns on the accumulator output and the remainder on the in-out output.

Signs are removed before the arithmetic and restored afterwards by bitwise complement. Both all-zeros and all-ones count as zero on input. A multiply handles several multiplier bits per cycle, and a divide produces several quotient bits per cycle. With the default widths a multiply finishes in 5 cycles and a divide in 6. A divide that cannot produce a fitting quotient finishes at once. It leaves both words unchanged and does not raise the skip flag. A successful divide raises the skip flag, which tells the sequencer to skip the next instruction.

Top module: `md_muldiv`

## Requirements
- R1: Multiply: `{ac_out, io_out}` equals the 2W-bit ones'-complement product of `io_in` and `mem_in`. The magnitude product is bitwise complemented across both words when exactly one operand has its MSB set (bit W-1 = 1 means negative). This applies to a zero product as well, and an all-ones operand counts as zero.
- R2: The `done` pulse of a multiply comes exactly ceil((W-1)/MUL_STEP) cycles after the clock edge that accepts `start`.
- R3: Divide with no overflow: let D be the magnitude of the 2W-bit ones'-complement value `{ac_in, io_in}` and d the magnitude of `mem_in`. Then `ac_out` is D/d, complemented when the dividend and divisor signs differ. `io_out` is D mod d, complemented when the dividend is negative.
- R4: `skip` is high together with `done` after a divide with no overflow, and is low at every other time.
- R5: Divide overflow occurs when D shifted right by W-1 is at least d, which includes d = 0. On overflow, `done` rises on the cycle after the accepting edge, `skip` stays low, and `ac_out` and `io_out` take the values of `ac_in` and `io_in`.
- R6: A `start` that arrives while `busy` is high is ignored: the operation in progress completes with its original operands and its original timing.
- R7: `done` is a single-cycle pulse unless a new start is accepted in that same cycle. `busy` is low whenever `done` is high.
- R8: After reset, `busy`, `done` and `skip` are low and both result words are zero.
- R9: The `done` pulse of a divide with no overflow comes exactly ceil((W-1)/DIV_STEP) cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| ac_in | input | W | Accumulator word (upper dividend half) |
| io_in | input | W | In-out word (multiplier operand, lower dividend half) |
| mem_in | input | W | Memory operand (multiplicand or divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| skip | output | 1 | Divide succeeded; skip next instruction |
| ac_out | output | W | High product word or quotient |
| io_out | output | W | Low product word or remainder |

## Verification
The bench builds the unit with W = 6, MUL_STEP = 2 and DIV_STEP = 2, so both operations take three stepping cycles. At this width every pair of multiply operands can be applied, covering all sign combinations and both zero encodings. Every accumulator and divisor value is swept against a spread of low dividend words, which reaches zero divisors, overflow just at the boundary and negative remainders. The narrow width also keeps the mismatch between the last stepping cycle and a partial final group of bits small enough to see.

// File: rtl/md_pkg.sv
package md_pkg;
  typedef enum logic {
    MD_MUL = 1'b0,
    MD_DIV = 1'b1
  } md_op_e;
endpackage

// File: rtl/md_oc_mag.sv
module md_oc_mag #(
  parameter int W = 18
) (
  input  logic [W-1:0] word_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o
);
  // A set MSB marks a negative ones'-complement value; its magnitude is the complement.
  assign neg_o = word_i[W-1];
  assign mag_o = word_i[W-1] ? ~word_i : word_i;
endmodule

// File: rtl/md_mul_core.sv
module md_mul_core #(
  parameter int W    = 18,
  parameter int STEP = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [W-2:0]   a_mag,
  input  logic [W-2:0]   b_mag,
  output logic           last,
  output logic [2*W-1:0] prod_nxt
);
  localparam int MW    = W - 1;
  localparam int ITERS = (MW + STEP - 1) / STEP;
  localparam int MPW   = ITERS * STEP;
  localparam int PW    = 2 * W;
  localparam int CW    = $clog2(ITERS + 1);

  logic          run;
  logic [CW-1:0] cnt;
  logic [PW-1:0] acc;
  logic [PW-1:0] mcand;
  logic [MPW-1:0] mplier;
  logic [PW-1:0] part;

  always_comb begin
    part = '0;
    for (int i = 0; i < STEP; i++) begin
      if (mplier[i]) part = part + (mcand << i);
    end
  end

  assign prod_nxt = acc + part;
  assign last     = run && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      cnt    <= '0;
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
    end else if (load) begin
      run    <= 1'b1;
      cnt    <= CW'(ITERS);
      acc    <= '0;
      mcand  <= PW'(a_mag);
      mplier <= MPW'(b_mag);
    end else if (run) begin
      acc    <= prod_nxt;
      mcand  <= mcand << STEP;
      mplier <= mplier >> STEP;
      cnt    <= cnt - CW'(1);
      if (last) run <= 1'b0;
    end
  end

  // R2: a running multiply always has steps left
  p_mul_steps_left_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0)) else $error("mul counter empty while running");

  // R6: the controller never reloads an operation in flight
  p_mul_no_reload_r6: assert property (@(posedge clk) disable iff (rst)
    load |-> !run) else $error("mul core reloaded while running");
endmodule

// File: rtl/md_div_core.sv
module md_div_core #(
  parameter int W    = 18,
  parameter int STEP = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [2*W-2:0] dvd_mag,
  input  logic [W-2:0]   dsr_mag,
  output logic           last,
  output logic [W-2:0]   quo_nxt,
  output logic [W-2:0]   rem_nxt
);
  localparam int ITERS = (W - 1 + STEP - 1) / STEP;
  localparam int QB    = ITERS * STEP;
  localparam int RW    = W;
  localparam int TW    = RW + 1;
  localparam int CW    = $clog2(ITERS + 1);

  logic          run;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rem;
  logic [QB-1:0] low;
  logic [QB-1:0] quo;
  logic [W-2:0]  dsr_q;

  logic [RW-1:0] r_w;
  logic [QB-1:0] lw_w;
  logic [QB-1:0] q_w;
  logic [TW-1:0] trial;

  // Restoring division, STEP quotient bits per cycle.
  always_comb begin
    r_w   = rem;
    lw_w  = low;
    q_w   = quo;
    trial = '0;
    for (int i = 0; i < STEP; i++) begin
      trial = {r_w, lw_w[QB-1]};
      lw_w  = lw_w << 1;
      if (trial >= TW'(dsr_q)) begin
        r_w = RW'(trial - TW'(dsr_q));
        q_w = (q_w << 1) | QB'(1);
      end else begin
        r_w = RW'(trial);
        q_w = q_w << 1;
      end
    end
  end

  assign quo_nxt = q_w[W-2:0];
  assign rem_nxt = r_w[W-2:0];
  assign last    = run && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      cnt   <= '0;
      rem   <= '0;
      low   <= '0;
      quo   <= '0;
      dsr_q <= '0;
    end else if (load) begin
      run   <= 1'b1;
      cnt   <= CW'(ITERS);
      rem   <= RW'(dvd_mag >> QB);
      low   <= QB'(dvd_mag);
      quo   <= '0;
      dsr_q <= dsr_mag;
    end else if (run) begin
      rem <= r_w;
      low <= lw_w;
      quo <= q_w;
      cnt <= cnt - CW'(1);
      if (last) run <= 1'b0;
    end
  end

  // R3: the partial remainder stays below the divisor throughout
  p_rem_below_dsr_r3: assert property (@(posedge clk) disable iff (rst)
    run |-> (rem < RW'(dsr_q))) else $error("partial remainder not below divisor");

  // R9: a running divide always has steps left
  p_div_steps_left_r9: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0)) else $error("div counter empty while running");
endmodule

// File: rtl/md_muldiv.sv
module md_muldiv
  import md_pkg::*;
#(
  parameter int W        = 18,
  parameter int MUL_STEP = 4,
  parameter int DIV_STEP = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op_div,
  input  logic [W-1:0] ac_in,
  input  logic [W-1:0] io_in,
  input  logic [W-1:0] mem_in,
  output logic         busy,
  output logic         done,
  output logic         skip,
  output logic [W-1:0] ac_out,
  output logic [W-1:0] io_out
);
  localparam int DW = 2 * W;

  logic [W-1:0]  io_mag, mem_mag;
  logic          io_neg, mem_neg;
  logic [DW-1:0] dvd_mag;
  logic          dvd_neg;

  md_oc_mag #(.W(W))  u_io_mag  (.word_i(io_in),          .mag_o(io_mag),  .neg_o(io_neg));
  md_oc_mag #(.W(W))  u_mem_mag (.word_i(mem_in),         .mag_o(mem_mag), .neg_o(mem_neg));
  md_oc_mag #(.W(DW)) u_dvd_mag (.word_i({ac_in, io_in}), .mag_o(dvd_mag), .neg_o(dvd_neg));

  md_op_e req_op, op_q;
  logic   accept, div_ovf, mul_load, div_load;
  logic   res_neg_q, rem_neg_q;

  assign req_op   = md_op_e'(op_div);
  assign accept   = start && !busy;
  assign div_ovf  = dvd_mag[DW-2:W-1] >= mem_mag;
  assign mul_load = accept && (req_op == MD_MUL);
  assign div_load = accept && (req_op == MD_DIV) && !div_ovf;

  logic          mul_last, div_last;
  logic [DW-1:0] mul_prod;
  logic [W-2:0]  div_quo, div_rem;

  md_mul_core #(.W(W), .STEP(MUL_STEP)) u_mul (
    .clk(clk), .rst(rst), .load(mul_load),
    .a_mag(io_mag[W-2:0]), .b_mag(mem_mag[W-2:0]),
    .last(mul_last), .prod_nxt(mul_prod)
  );

  md_div_core #(.W(W), .STEP(DIV_STEP)) u_div (
    .clk(clk), .rst(rst), .load(div_load),
    .dvd_mag(dvd_mag[DW-2:0]), .dsr_mag(mem_mag[W-2:0]),
    .last(div_last), .quo_nxt(div_quo), .rem_nxt(div_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      skip      <= 1'b0;
      ac_out    <= '0;
      io_out    <= '0;
      op_q      <= MD_MUL;
      res_neg_q <= 1'b0;
      rem_neg_q <= 1'b0;
    end else begin
      done <= 1'b0;
      skip <= 1'b0;
      if (accept) begin
        if (req_op == MD_DIV && div_ovf) begin
          done   <= 1'b1;
          ac_out <= ac_in;
          io_out <= io_in;
        end else begin
          busy      <= 1'b1;
          op_q      <= req_op;
          res_neg_q <= (req_op == MD_MUL) ? (io_neg ^ mem_neg) : (dvd_neg ^ mem_neg);
          rem_neg_q <= dvd_neg;
        end
      end else if (busy) begin
        if (op_q == MD_MUL && mul_last) begin
          {ac_out, io_out} <= res_neg_q ? ~mul_prod : mul_prod;
          busy <= 1'b0;
          done <= 1'b1;
        end else if (op_q == MD_DIV && div_last) begin
          ac_out <= res_neg_q ? ~{1'b0, div_quo} : {1'b0, div_quo};
          io_out <= rem_neg_q ? ~{1'b0, div_rem} : {1'b0, div_rem};
          skip   <= 1'b1;
          busy   <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  // R7: completion is a single-cycle pulse unless a new start lands on it
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done) else $error("done held longer than one cycle");

  // R7: never busy while reporting completion
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) else $error("busy during done");

  // R4: skip only appears together with completion
  p_skip_with_done_r4: assert property (@(posedge clk) disable iff (rst)
    skip |-> done) else $error("skip without done");

  // R5: overflow returns the inputs at once without a skip
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && op_div && div_ovf) |=>
      (done && !skip && ac_out == $past(ac_in) && io_out == $past(io_in)))
    else $error("divide overflow handling wrong");

  // R6: a start while busy leaves the operation kind untouched
  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> (op_q == $past(op_q))) else $error("start accepted while busy");
endmodule

// File: tb/md_muldiv_tb_top.sv
module md_muldiv_tb_top;
  localparam int W    = 6;
  localparam int MASK = (1 << W) - 1;
  localparam int DMSK = (1 << (2 * W)) - 1;
  localparam int LAT  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic op_div = 1'b0;
  logic [W-1:0] ac_in = '0, io_in = '0, mem_in = '0;
  logic busy, done, skip;
  logic [W-1:0] ac_out, io_out;

  int total = 0;
  int bad   = 0;
  int lat;

  always #4 clk = ~clk;

  md_muldiv #(.W(W), .MUL_STEP(2), .DIV_STEP(2)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op_div(op_div),
    .ac_in(ac_in), .io_in(io_in), .mem_in(mem_in),
    .busy(busy), .done(done), .skip(skip),
    .ac_out(ac_out), .io_out(io_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mag6(input int x);
    return x[W-1] ? (MASK - x) : x;
  endfunction

  // Apply one operation and wait for done; lat counts falling edges after the accepting edge.
  task automatic run_op(input bit dv, input int a, input int i, input int m);
    @(negedge clk);
    start = 1'b1; op_div = dv;
    ac_in = W'(a); io_in = W'(i); mem_in = W'(m);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic post_done(input string req);
    check(busy == 1'b0, req, int'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, req, int'(done), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int pm, ea, ei, dm, dd, q, r;
    bit neg, ovf, sd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check(busy == 1'b0 && done == 1'b0 && skip == 1'b0, "R8 flags", {busy, done, skip}, 0);
    check(ac_out == '0 && io_out == '0, "R8 words", int'({ac_out, io_out}), 0);

    // R1, R2: every multiply operand pair
    for (int i = 0; i <= MASK; i++) begin
      for (int m = 0; m <= MASK; m++) begin
        run_op(1'b0, 0, i, m);
        pm  = mag6(i) * mag6(m);
        neg = i[W-1] ^ m[W-1];
        ea  = neg ? (DMSK - pm) : pm;
        check(int'({ac_out, io_out}) == ea, "R1 product", int'({ac_out, io_out}), ea);
        check(lat == LAT, "R2 mul latency", lat, LAT);
        check(skip == 1'b0, "R4 no skip on mul", int'(skip), 0);
        post_done("R7 mul done pulse");
      end
    end

    // R3, R4, R5, R9: divide sweep
    for (int a = 0; a <= MASK; a++) begin
      for (int k = 0; k < 4; k++) begin
        ei = (k * 21) & MASK;
        for (int m = 0; m <= MASK; m++) begin
          run_op(1'b1, a, ei, m);
          dd  = a * (MASK + 1) + ei;
          sd  = a[W-1];
          if (sd) dd = DMSK - dd;
          dm  = mag6(m);
          ovf = (dd >> (W - 1)) >= dm;
          if (ovf) begin
            check(ac_out == W'(a) && io_out == W'(ei), "R5 overflow words",
                  int'({ac_out, io_out}), a * (MASK + 1) + ei);
            check(skip == 1'b0, "R5 overflow skip", int'(skip), 0);
            check(lat == 0, "R5 overflow latency", lat, 0);
          end else begin
            q = dd / dm;
            r = dd % dm;
            if (sd ^ m[W-1]) q = MASK - q;
            if (sd) r = MASK - r;
            check(int'(ac_out) == q, "R3 quotient", int'(ac_out), q);
            check(int'(io_out) == r, "R3 remainder", int'(io_out), r);
            check(skip == 1'b1, "R4 skip on success", int'(skip), 1);
            check(lat == LAT, "R9 div latency", lat, LAT);
          end
          post_done("R7 div done pulse");
        end
      end
    end

    // R6: a start during busy is ignored (multiply 5*7 kept, divide attempt dropped)
    @(negedge clk);
    start = 1'b1; op_div = 1'b0; io_in = 6'd5; mem_in = 6'd7;
    @(negedge clk);
    start = 1'b1; op_div = 1'b1; ac_in = 6'd1; io_in = 6'd0; mem_in = 6'd3;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(int'({ac_out, io_out}) == 35, "R6 busy start ignored", int'({ac_out, io_out}), 35);
    check(lat == LAT, "R6 timing unchanged", lat, LAT);
    check(skip == 1'b0, "R6 no skip from dropped divide", int'(skip), 0);
    post_done("R7 after ignored start");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule